// File: doc/BRIEF.md
# Byte/Word Configurable ROM Read Port

This block is the read side of a parallel nonvolatile memory. The memory holds 16-bit words. It can be read either as 16-bit words or as 8-bit bytes, and a mode input selects which. In byte mode the top data line changes role: it stops carrying data bit 15 and becomes an extra least-significant address input that picks the low or high half of the addressed word. Real tristates are not used. The block drives a per-bit output-enable vector next to the data, and the pad ring turns that into pad drivers.

Data is driven only when both the chip-select and the output-gate controls are active-low asserted. A separate high-voltage flag on address line 9 switches the port into an identifier readout. In that mode one of two fixed codes replaces the array data. The storage is an internal array, parameterised in depth, and each entry is loaded with a value computed from its address. Every output is registered one clock after its inputs are sampled.

Top module: `rom_read_port`

## Requirements
- R1: With `wide_i`=1, `ce_ni`=0, `oe_ni`=0 and no identifier readout, `data_o` equals the addressed 16-bit word and `data_oe_o` is 16'hFFFF.
- R2: With `wide_i`=0 and both controls asserted, `data_oe_o` is 16'h00FF and `data_o[15:8]` is zero, so bit 15 is not driven and serves as the `lsb_i` input.
- R3: In byte mode, `lsb_i`=0 places bits 7..0 of the addressed word on `data_o[7:0]`, and `lsb_i`=1 places bits 15..8 there.
- R4: With `ce_ni`=1, `data_oe_o` and `data_o` are zero whatever `oe_ni` is.
- R5: With `ce_ni`=0 and `oe_ni`=1, `data_oe_o` and `data_o` are zero.
- R6: All outputs change one clock after their inputs are sampled, and data and enable change in the same cycle. While `rst_ni` is low, `data_o`, `data_oe_o` and `id_err_o` are zero.
- R7: When `id_hv_i`=1 and every address bit other than bit 0 and bit 9 is zero, the read returns 8'h20 when `addr_i[0]`=0 and 8'h32 when `addr_i[0]`=1. The code appears on `data_o[7:0]` and `data_o[15:8]` is zero. The enable vector follows R1/R2. In byte mode `lsb_i` has no effect on the code.
- R8: When `id_hv_i`=1 and any address bit other than bit 0 and bit 9 is nonzero, `id_err_o` is set from the next cycle and stays set until reset, and the read returns the array word exactly as in normal mode.
- R9: The array word at address `a` is `(a[15:0] * 16'h9E37) ^ 16'h5A5A`, truncated to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| id_hv_i | input | 1 | High-voltage flag on address line 9; requests identifier readout |
| wide_i | input | 1 | 1 selects word organisation, 0 selects byte organisation |
| ce_ni | input | 1 | Chip select, active low; high means standby |
| oe_ni | input | 1 | Output gate, active low |
| lsb_i | input | 1 | Half-word select, used in byte mode only |
| data_o | output | 16 | Registered read data |
| data_oe_o | output | 16 | Per-bit drive enable for `data_o` |
| id_err_o | output | 1 | Sticky flag: identifier readout requested with a bad address |

## Verification
The assertions assume that `lsb_i` is only meaningful in byte mode. They also assume that every input is settled at each rising edge, because each property relates one sampled cycle to the registered result in the next. The stimulus drives all inputs on falling edges only. Random addresses are biased so that valid identifier addresses, out-of-range identifier requests and plain reads all occur. Directed cases cover the mode and control corners and a second reset that must clear the sticky flag.

// File: rtl/rom_rp_pkg.sv
package rom_rp_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [7:0] ID_CODE_LO = 8'h20;
  localparam logic [7:0] ID_CODE_HI = 8'h32;

  function automatic logic [DATA_W-1:0] rom_word(input logic [31:0] a);
    logic [15:0] m;
    m = a[15:0] * 16'h9E37;
    return m ^ 16'h5A5A;
  endfunction
endpackage

// File: rtl/rom_array.sv
module rom_array #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic [rom_rp_pkg::DATA_W-1:0]     word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [rom_rp_pkg::DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign mem[i] = rom_rp_pkg::rom_word(i);
  end

  assign word_o = mem[addr_i];
endmodule

// File: rtl/rom_id_decode.sv
module rom_id_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ID_BIT = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_hv_i,
  output logic              id_ok_o,
  output logic              id_bad_o,
  output logic [7:0]        id_code_o
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);

  logic others_set;
  assign others_set = |(addr_i & ~KEEP_MASK);
  assign id_ok_o    = id_hv_i & ~others_set;
  assign id_bad_o   = id_hv_i & others_set;
  assign id_code_o  = addr_i[0] ? rom_rp_pkg::ID_CODE_HI : rom_rp_pkg::ID_CODE_LO;
endmodule

// File: rtl/rom_out_stage.sv
module rom_out_stage
  import rom_rp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] arr_word_i,
  input  logic              id_ok_i,
  input  logic              id_bad_i,
  input  logic [7:0]        id_code_i,
  input  logic              wide_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              lsb_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              id_err_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] sel_word, d_nxt, oe_nxt;
  logic [HALF-1:0]   byte_sel;
  logic              drive;

  assign sel_word = id_ok_i ? {{HALF{1'b0}}, id_code_i} : arr_word_i;
  assign drive    = ~ce_ni & ~oe_ni;
  // identifier code always sits in the low half
  assign byte_sel = (id_ok_i | ~lsb_i) ? sel_word[HALF-1:0] : sel_word[DATA_W-1:HALF];

  always_comb begin
    d_nxt  = '0;
    oe_nxt = '0;
    if (drive) begin
      if (wide_i) begin
        d_nxt  = sel_word;
        oe_nxt = '1;
      end else begin
        d_nxt  = {{HALF{1'b0}}, byte_sel};
        oe_nxt = {{HALF{1'b0}}, {HALF{1'b1}}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      data_oe_o <= '0;
      id_err_o  <= 1'b0;
    end else begin
      data_o    <= d_nxt;
      data_oe_o <= oe_nxt;
      id_err_o  <= id_err_o | id_bad_i;
    end
  end
endmodule

// File: rtl/rom_read_port.sv
module rom_read_port #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ID_BIT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_hv_i,
  input  logic              wide_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              lsb_i,
  output logic [15:0]       data_o,
  output logic [15:0]       data_oe_o,
  output logic              id_err_o
);
  logic [15:0] arr_word;
  logic        id_ok, id_bad;
  logic [7:0]  id_code;

  rom_array #(.ADDR_W(ADDR_W)) u_array (
    .addr_i (addr_i),
    .word_o (arr_word)
  );

  rom_id_decode #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_id (
    .addr_i    (addr_i),
    .id_hv_i   (id_hv_i),
    .id_ok_o   (id_ok),
    .id_bad_o  (id_bad),
    .id_code_o (id_code)
  );

  rom_out_stage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arr_word_i (arr_word),
    .id_ok_i    (id_ok),
    .id_bad_i   (id_bad),
    .id_code_i  (id_code),
    .wide_i     (wide_i),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .lsb_i      (lsb_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .id_err_o   (id_err_o)
  );
endmodule

// File: rtl/rom_read_port_chk.sv
module rom_read_port_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ID_BIT = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              id_hv_i,
  input logic              wide_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              lsb_i,
  input logic [15:0]       data_o,
  input logic [15:0]       data_oe_o,
  input logic              id_err_o
);
  localparam logic [ADDR_W-1:0] KEEP = (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);

  AST_STANDBY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (data_oe_o == '0 && data_o == '0)); // R4
  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |=> (data_oe_o == '0 && data_o == '0)); // R5
  AST_WORD_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && wide_i) |=> data_oe_o == 16'hFFFF); // R1
  AST_BYTE_UPPER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> (data_oe_o[15:8] == 8'h00 && data_o[15:8] == 8'h00)); // R2
  AST_ID_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && id_hv_i && (addr_i & ~KEEP) == '0)
      |=> (data_o[15:8] == 8'h00 && (data_o[7:0] == 8'h20 || data_o[7:0] == 8'h32))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_err_o |=> id_err_o); // R8
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_hv_i && (addr_i & ~KEEP) != '0) |=> id_err_o); // R8
  AST_LSB_BYTE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && $past(wide_i) && $stable(addr_i) && $stable(id_hv_i) && !ce_ni && !oe_ni
     && $past(!ce_ni && !oe_ni) && $changed(lsb_i)) |=> $stable(data_o)); // R1
endmodule

bind rom_read_port rom_read_port_chk #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .id_hv_i(id_hv_i),
  .wide_i(wide_i), .ce_ni(ce_ni), .oe_ni(oe_ni), .lsb_i(lsb_i),
  .data_o(data_o), .data_oe_o(data_oe_o), .id_err_o(id_err_o)
);

// File: tb/rom_read_port_tb_top.sv
module rom_read_port_tb_top;
  localparam int unsigned ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              id_hv = 1'b0, wide = 1'b1, ce_n = 1'b1, oe_n = 1'b1, lsb = 1'b0;
  logic [15:0]       data, data_oe;
  logic              id_err;

  int checks = 0, errors = 0;
  logic err_model = 1'b0;

  always #5 clk = ~clk;

  rom_read_port #(.ADDR_W(ADDR_W), .ID_BIT(9)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .id_hv_i(id_hv), .wide_i(wide),
    .ce_ni(ce_n), .oe_ni(oe_n), .lsb_i(lsb),
    .data_o(data), .data_oe_o(data_oe), .id_err_o(id_err)
  );

  function automatic logic [15:0] word_at(input logic [ADDR_W-1:0] a);
    logic [15:0] p;
    p = 16'(a) * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  function automatic logic id_valid(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = a;
    m[0] = 1'b0;
    m[9] = 1'b0;
    return m == '0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply inputs at negedge, check registered result at next negedge
  task automatic cyc(input logic [ADDR_W-1:0] a, input logic hv, input logic w,
                     input logic ce, input logic oe, input logic l, input string req);
    logic [15:0] w16, ed, eo;
    logic idm;
    addr = a; id_hv = hv; wide = w; ce_n = ce; oe_n = oe; lsb = l;
    idm = hv && id_valid(a);
    w16 = idm ? {8'h00, (a[0] ? 8'h32 : 8'h20)} : word_at(a);
    ed = '0; eo = '0;
    if (!ce && !oe) begin
      if (w) begin ed = w16; eo = 16'hFFFF; end
      else begin
        ed = {8'h00, (idm || !l) ? w16[7:0] : w16[15:8]};
        eo = 16'h00FF;
      end
    end
    if (hv && !id_valid(a)) err_model = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(data == ed, req, 32'(data), 32'(ed));
    check(data_oe == eo, req, 32'(data_oe), 32'(eo));
    check(id_err == err_model, {req, "/R8 flag"}, 32'(id_err), 32'(err_model));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R6 reset state
    check(data == 0 && data_oe == 0 && id_err == 0, "R6 reset", {data, data_oe}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R6 one-clock latency: input change visible only after edge
    addr = 10'h005; wide = 1; ce_n = 0; oe_n = 0;
    #1 check(data_oe == 0, "R6 latency", 32'(data_oe), 0);
    cyc(10'h005, 0, 1, 0, 0, 0, "R1 word read");
    cyc(10'h3FF, 0, 1, 0, 0, 1, "R9 top address");
    cyc(10'h000, 0, 1, 0, 0, 0, "R9 address zero");
    cyc(10'h123, 0, 0, 0, 0, 0, "R3 byte low");
    cyc(10'h123, 0, 0, 0, 0, 1, "R3 byte high");
    cyc(10'h2A7, 0, 0, 0, 0, 1, "R2 byte mode");
    cyc(10'h123, 0, 1, 1, 0, 0, "R4 standby oe low");
    cyc(10'h123, 0, 1, 1, 1, 0, "R4 standby oe high");
    cyc(10'h123, 0, 1, 0, 1, 0, "R5 gate off");
    cyc(10'h200, 1, 1, 0, 0, 0, "R7 code lo word");
    cyc(10'h201, 1, 1, 0, 0, 0, "R7 code hi word");
    cyc(10'h001, 1, 0, 0, 0, 1, "R7 code hi byte lsb ignored");
    cyc(10'h000, 1, 0, 0, 0, 1, "R7 code lo byte lsb ignored");
    cyc(10'h201, 1, 1, 1, 0, 0, "R7 code in standby");
    cyc(10'h241, 1, 1, 0, 0, 0, "R8 bad id address");
    cyc(10'h000, 0, 1, 0, 0, 0, "R8 sticky");
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      logic hv;
      int unsigned r;
      r = $urandom % 8;
      a = ADDR_W'($urandom);
      hv = (r < 3);
      if (r < 2) begin a = '0; a[0] = 1'($urandom); a[9] = 1'($urandom); end
      cyc(a, hv, 1'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0, 1'($urandom), "R1/R2/R3/R7 random");
    end
    // second reset clears sticky flag (R6, R8)
    @(negedge clk);
    rst_ni = 1'b0;
    err_model = 1'b0;
    #1 check(id_err == 0 && data_oe == 0, "R8 reset clears flag", 32'(id_err), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(10'h201, 1, 0, 0, 0, 0, "R7 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule